// File: doc/BRIEF.md
# Line Code Violation Status Toggles

This block turns the stream of bipolar line code violations flagged by a DS1 receiver into three slowly changing status bits that software can poll at leisure. Each bit flips state after a fixed number of violations, so software reads two samples of a bit some time apart and infers from the change how many violations occurred in between. The block's inputs are a one-cycle violation strobe from the line decoder and a one-cycle strobe from a 1 ms timebase.

Two of the bits, the mid and fine toggles, flip after every 128 and every 64 violations respectively. They count without pause and take no notice of the timebase. The third, the coarse toggle, flips after 256 violations, and it also has a minimum refresh interval of 96 timebase ticks. When 256 violations arrive faster than that, the coarse toggle holds back until the interval has passed. Any violations that arrive while it holds back are dropped. This sets an upper limit on the error rate that the coarse bit can show.

Top module: `lcv_status`

## Requirements
- R1: With the interval already elapsed, the coarse toggle flips at the same clock edge that registers the 256th violation since its last flip or reset.
- R2: Two flips of the coarse toggle are always separated by at least 96 timebase ticks.
- R3: When 256 violations accumulate before the interval has elapsed, the coarse toggle flips on the first clock edge after the edge that registers the 96th tick. Violations that arrive during this wait are discarded and do not count toward the next flip.
- R4: When the 256 violations take longer than the interval, the flip happens on the edge of the 256th violation, with no extra delay.
- R5: The mid toggle flips after every 128 violations. Neither the interval nor the coarse toggle's state affects it.
- R6: The fine toggle flips after every 64 violations. Neither the interval nor the coarse toggle's state affects it.
- R7: Timebase ticks alone never change the mid or fine toggle.
- R8: Each coarse flip clears the coarse violation count to zero and restarts the interval count from zero. A violation that lands in the same cycle as a delayed flip is discarded.
- R9: After reset, all three toggles read 0, every count is zero, and the interval counts as already elapsed.
- R10: The coarse violation count saturates at 256, and the interval count saturates at 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| viol_pulse_i | input | 1 | One-cycle strobe for each line code violation |
| ms_tick_i | input | 1 | One-cycle strobe from the 1 ms timebase |
| stat_coarse_o | output | 1 | Rate-limited toggle that flips every 256 violations |
| stat_mid_o | output | 1 | Toggle that flips every 128 violations |
| stat_fine_o | output | 1 | Toggle that flips every 64 violations |

## Verification
The hardest case to reach is a coarse count that saturates while the interval is still running, followed by a release exactly one cycle after the 96th tick. The stimulus reaches it by first forcing a flip, then sending 256 violations and ten more with no ticks, and then sending ticks one at a time. The outputs are sampled at the edge of the last tick and again at the edge after it. Later vectors need a full 256 fresh violations before the next flip, and this shows that the extra violations were dropped.

// File: rtl/lcv_status_pkg.sv
package lcv_status_pkg;

  // Bits needed to hold the values 0..n inclusive, never less than one.
  function automatic int unsigned hold_w(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Indices of the uncapped toggles in the fine divider bank.
  typedef enum int unsigned {
    IDX_FINE = 0,
    IDX_MID  = 1
  } fine_idx_e;

  localparam int unsigned N_UNCAPPED = 2;

endpackage

// File: rtl/lcv_rst_sync.sv
module lcv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/lcv_toggle_div.sv
module lcv_toggle_div #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic tgl_o
);

  import lcv_status_pkg::*;

  localparam int unsigned CW = hold_w(DIV - 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;
  logic          wrap;

  always_comb begin
    wrap  = step_i && (cnt_q == LAST);
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (step_i) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    if (wrap) begin
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign tgl_o = tgl_q;

endmodule

// File: rtl/lcv_interval_timer.sv
module lcv_interval_timer #(
  parameter int unsigned LIMIT = 96
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick_i,
  input  logic                               restart_i,
  output logic                               elapsed_o,
  output logic [lcv_status_pkg::hold_w(LIMIT)-1:0] ticks_o
);

  import lcv_status_pkg::*;

  localparam int unsigned TW = hold_w(LIMIT);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] ticks_q, ticks_d;
  logic          done;
  logic          en;

  always_comb begin
    done    = (ticks_q == TOP);
    en      = restart_i || (tick_i && !done);
    ticks_d = ticks_q;
    if (restart_i) begin
      ticks_d = '0;
    end else if (tick_i && !done) begin
      ticks_d = ticks_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_q <= TOP;
    end else if (en) begin
      ticks_q <= ticks_d;
    end
  end

  assign elapsed_o = done;
  assign ticks_o   = ticks_q;

endmodule

// File: rtl/lcv_coarse_gate.sv
module lcv_coarse_gate #(
  parameter int unsigned THRESH = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  viol_i,
  input  logic                                  elapsed_i,
  output logic                                  fire_o,
  output logic                                  tgl_o,
  output logic [lcv_status_pkg::hold_w(THRESH)-1:0] cnt_o
);

  import lcv_status_pkg::*;

  localparam int unsigned CW = hold_w(THRESH);
  localparam logic [CW-1:0] FULL     = CW'(THRESH);
  localparam logic [CW-1:0] NEARFULL = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;
  logic          reached;
  logic          fire;
  logic          en;

  always_comb begin
    reached = (cnt_q == FULL) || (viol_i && (cnt_q == NEARFULL));
    fire    = reached && elapsed_i;
    en      = fire || (viol_i && (cnt_q != FULL));
    cnt_d   = cnt_q;
    tgl_d   = tgl_q ^ fire;
    if (fire) begin
      cnt_d = '0;
    end else if (viol_i && (cnt_q != FULL)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign fire_o = fire;
  assign tgl_o  = tgl_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/lcv_status.sv
module lcv_status #(
  parameter int unsigned VIOL_COARSE  = 256,
  parameter int unsigned VIOL_MID     = 128,
  parameter int unsigned VIOL_FINE    = 64,
  parameter int unsigned MIN_INTERVAL = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_pulse_i,
  input  logic ms_tick_i,
  output logic stat_coarse_o,
  output logic stat_mid_o,
  output logic stat_fine_o
);

  import lcv_status_pkg::*;

  localparam int unsigned CW = hold_w(VIOL_COARSE);
  localparam int unsigned TW = hold_w(MIN_INTERVAL);
  localparam logic [N_UNCAPPED-1:0][31:0] DIVS = {32'(VIOL_MID), 32'(VIOL_FINE)};

  logic                  rst_n_int;
  logic                  elapsed;
  logic                  fire;
  logic [CW-1:0]         coarse_cnt;
  logic [TW-1:0]         interval_ticks;
  logic [N_UNCAPPED-1:0] uncapped;

  lcv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lcv_interval_timer #(.LIMIT(MIN_INTERVAL)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_i    (ms_tick_i),
    .restart_i (fire),
    .elapsed_o (elapsed),
    .ticks_o   (interval_ticks)
  );

  lcv_coarse_gate #(.THRESH(VIOL_COARSE)) u_coarse (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .viol_i    (viol_pulse_i),
    .elapsed_i (elapsed),
    .fire_o    (fire),
    .tgl_o     (stat_coarse_o),
    .cnt_o     (coarse_cnt)
  );

  for (genvar g = 0; g < N_UNCAPPED; g++) begin : g_uncapped
    lcv_toggle_div #(.DIV(int'(DIVS[g]))) u_div (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .step_i (viol_pulse_i),
      .tgl_o  (uncapped[g])
    );
  end

  assign stat_fine_o = uncapped[IDX_FINE];
  assign stat_mid_o  = uncapped[IDX_MID];

endmodule

// File: rtl/lcv_status_checker.sv
module lcv_status_checker #(
  parameter int unsigned VIOL_COARSE  = 256,
  parameter int unsigned VIOL_MID     = 128,
  parameter int unsigned VIOL_FINE    = 64,
  parameter int unsigned MIN_INTERVAL = 96
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         viol,
  input logic                                         coarse,
  input logic                                         mid,
  input logic                                         fine,
  input logic                                         elapsed,
  input logic [lcv_status_pkg::hold_w(VIOL_COARSE)-1:0]  cnt,
  input logic [lcv_status_pkg::hold_w(MIN_INTERVAL)-1:0] ticks
);

  p_coarse_waits_interval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coarse) |-> $past(elapsed));

  p_coarse_needs_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coarse) |-> ($past(cnt) >= (VIOL_COARSE - 1)));

  p_restart_after_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coarse) |-> (ticks == '0 && cnt == '0));

  p_count_capped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (VIOL_COARSE));

  p_ticks_capped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ticks <= (MIN_INTERVAL));

  p_fine_needs_viol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fine) |-> $past(viol));

  p_mid_needs_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mid) |-> $past(viol));

  if (VIOL_MID % VIOL_FINE == 0) begin : g_nested
    p_mid_with_fine_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mid) |-> !$stable(fine));
  end

endmodule

bind lcv_status lcv_status_checker #(
  .VIOL_COARSE  (VIOL_COARSE),
  .VIOL_MID     (VIOL_MID),
  .VIOL_FINE    (VIOL_FINE),
  .MIN_INTERVAL (MIN_INTERVAL)
) u_lcv_status_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .viol    (viol_pulse_i),
  .coarse  (stat_coarse_o),
  .mid     (stat_mid_o),
  .fine    (stat_fine_o),
  .elapsed (elapsed),
  .cnt     (coarse_cnt),
  .ticks   (interval_ticks)
);

// File: tb/lcv_status_bench.sv
module lcv_status_bench;

  logic clk;
  logic rst_n;
  logic viol;
  logic tick;
  logic c_o, m_o, f_o;

  int checks = 0;
  int errors = 0;

  lcv_status u_lcv_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .viol_pulse_i  (viol),
    .ms_tick_i     (tick),
    .stat_coarse_o (c_o),
    .stat_mid_o    (m_o),
    .stat_fine_o   (f_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {violations[9:0], ticks[7:0], coarse, mid, fine}
  localparam int NV = 11;
  localparam logic [NV-1:0][20:0] VEC = {
    {10'd1,   8'd0,   3'b100},  // 10: R4 slow case, flips on 256th
    {10'd255, 8'd0,   3'b000},  // 9 : R8 fresh count needs 256
    {10'd0,   8'd100, 3'b000},  // 8 : R10 ticks saturate, R7 no fine change
    {10'd0,   8'd1,   3'b000},  // 7 : R3 delayed release
    {10'd10,  8'd95,  3'b100},  // 6 : R3 extra violations dropped
    {10'd256, 8'd0,   3'b100},  // 5 : R2 held back, R5 R6 keep counting
    {10'd1,   8'd0,   3'b100},  // 4 : R1 256th flips coarse
    {10'd127, 8'd0,   3'b011},  // 3 : R6 192
    {10'd64,  8'd0,   3'b010},  // 2 : R5 128
    {10'd1,   8'd0,   3'b001},  // 1 : R6 64
    {10'd63,  8'd0,   3'b000}   // 0 : R6 63
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [2:0] exp);
    check(req, c_o, exp[2], "coarse");
    check(req, m_o, exp[1], "mid");
    check(req, f_o, exp[0], "fine");
  endtask

  task automatic send_viol(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) viol = 1'b1;
    end
    @(negedge clk) viol = 1'b0;
  endtask

  task automatic send_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    viol  = 1'b0;
    tick  = 1'b0;
    do_reset();
    check_all("R9 reset", 3'b000);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20:11] != 0) send_viol(int'(VEC[k][20:11]));
      if (VEC[k][10:3]  != 0) send_tick(int'(VEC[k][10:3]));
      idle(2);
      check_all($sformatf("R1-vec%0d", k), VEC[k][2:0]);
    end

    // R9: mid-run reset clears toggles and leaves interval elapsed
    send_viol(64);
    do_reset();
    check_all("R9 after reset", 3'b000);
    send_viol(255);
    check("R1", c_o, 1'b0, "coarse at 255");
    send_viol(1);
    check("R1", c_o, 1'b1, "coarse at 256 right after edge");

    // R3: exact release cycle after the 96th tick
    send_viol(256);
    send_tick(95);
    check("R3", c_o, 1'b1, "held before last tick");
    send_tick(1);
    check("R3", c_o, 1'b1, "held at edge of 96th tick");
    idle(1);
    check("R3", c_o, 1'b0, "released one edge later");

    // R7: ticks alone leave mid and fine alone
    send_tick(200);
    check("R7", m_o, 1'b0, "mid after ticks");
    check("R7", f_o, 1'b0, "fine after ticks");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule